// File: doc/BRIEF.md
# Low-speed USB NRZI packet receiver

This block turns the sampled levels of a low-speed USB differential pair into packet bytes. The surrounding logic has already found the sync pattern and pulses `start` at the beginning of the first bit period that follows it. From then on the block samples the lines once every eight clock cycles at a fixed phase. It reverses the NRZI line coding and drops the bits inserted for stuffing as they arrive. It then gathers the bits into bytes, least significant bit first.

Each finished byte is presented on `rx_byte` with a one-cycle `byte_valid` strobe. A single-ended zero on the pair ends the packet with a one-cycle `eop` pulse, and any byte left unfinished is dropped. Before each packet the caller loads a byte budget through `limit`. When a byte completes after the budget is used up, the block gives a one-cycle `overflow` pulse instead of the byte and stops receiving.

Top module: `lsusb_nrzi_rx`

## Requirements
- R1: A synchronous reset leaves the block idle with `busy`, `byte_valid`, `eop` and `overflow` low. It sets the remembered line level to idle J (D- high) and clears the ones-run and bit counters.
- R2: After `start` is taken at clock edge E0, bit k is sampled at edge E0+1+SAMPLE_AT+8k (SAMPLE_AT defaults to 3). The D- level is the data sample. All result pulses are produced at a sample edge.
- R3: A sampled D- level equal to the previous one decodes as 1, and a change decodes as 0. The reference level for the first bit is the D- level at the `start` edge.
- R4: The bit after a run of six decoded 1s is discarded, whatever its value. The 1 that ends the sync pattern counts as the first bit of that run. Sampling continues on the same eight-cycle grid, so no data bit is lost across the dropped one.
- R5: The first decoded data bit is bit 0 of a byte. After eight data bits the byte appears on `rx_byte` with `byte_valid` high for one cycle.
- R6: D+ and D- both low at a sample point give a one-cycle `eop` pulse and return the block to idle. A partially assembled byte is not output.
- R7: With budget L loaded at `start`, the first L completed bytes are output. Completing byte L+1 raises `overflow` for one cycle instead of `byte_valid`. Reception then stops, and no `eop` follows for that packet.
- R8: While idle, line activity (including SE0) produces no output pulse and does not start reception. Only `start` begins a packet.
- R9: At most one of `byte_valid`, `eop` and `overflow` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, eight cycles per low-speed bit |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin reception (taken only while idle) |
| dp | input | 1 | D+ line level |
| dm | input | 1 | D- line level, the data sample |
| limit | input | CNT_W | Byte budget for the packet, loaded at start |
| rx_byte | output | 8 | Last completed byte |
| byte_valid | output | 1 | One-cycle strobe for `rx_byte` |
| eop | output | 1 | One-cycle end-of-packet pulse |
| overflow | output | 1 | One-cycle budget overflow pulse |
| busy | output | 1 | High while a packet is being received |

## Verification
The bench NRZI-encodes its own byte streams and inserts stuffing bits itself before driving the pair. All 256 byte values are sent across sixteen packets, which separates a wrong bit order or an inverted decode from correct output. Runs of 0xFF force stuffing points inside a byte and across byte boundaries, which exposes a stuffed bit that is kept or a grid that slips. Packets that end mid-byte, overrun a budget of two, or have a budget of zero separate the end and overflow rules. The cycle on which `eop` appears pins down the sampling phase. A stretch of line toggling while idle shows that nothing starts without `start`.

// File: rtl/lsusb_nrzi_rx.sv
module lsusb_nrzi_rx #(
  parameter int BIT_CYCLES = 8,
  parameter int SAMPLE_AT  = 3,
  parameter int RUN_MAX    = 6,
  parameter int CNT_W      = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             dp,
  input  logic             dm,
  input  logic [CNT_W-1:0] limit,
  output logic [7:0]       rx_byte,
  output logic             byte_valid,
  output logic             eop,
  output logic             overflow,
  output logic             busy
);
  localparam int PH_W  = $clog2(BIT_CYCLES);
  localparam int RUN_W = $clog2(RUN_MAX + 1);

  logic [PH_W-1:0]  phase;
  logic             prev;
  logic [RUN_W-1:0] run;
  logic [2:0]       nbit;
  logic [6:0]       acc;
  logic [CNT_W-1:0] left;

  wire tick    = busy && (phase == PH_W'(SAMPLE_AT));
  wire se0     = !dp && !dm;
  wire bit_val = (dm == prev);
  wire stuffed = (run == RUN_W'(RUN_MAX));
  wire [PH_W-1:0] phase_nx = (phase == PH_W'(BIT_CYCLES - 1)) ? '0 : phase + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      phase      <= '0;
      prev       <= 1'b1;
      run        <= '0;
      nbit       <= '0;
      acc        <= '0;
      left       <= '0;
      rx_byte    <= '0;
      byte_valid <= 1'b0;
      eop        <= 1'b0;
      overflow   <= 1'b0;
    end else begin
      byte_valid <= 1'b0;
      eop        <= 1'b0;
      overflow   <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy  <= 1'b1;
          phase <= '0;
          prev  <= dm;
          run   <= RUN_W'(1);
          nbit  <= '0;
          left  <= limit;
        end
      end else begin
        phase <= phase_nx;
        if (tick) begin
          if (se0) begin
            eop  <= 1'b1;
            busy <= 1'b0;
          end else begin
            prev <= dm;
            if (stuffed) begin
              run <= '0;
            end else begin
              run  <= bit_val ? run + 1'b1 : '0;
              acc  <= {bit_val, acc[6:1]};
              nbit <= nbit + 1'b1;
              if (nbit == 3'd7) begin
                if (left == '0) begin
                  overflow <= 1'b1;
                  busy     <= 1'b0;
                end else begin
                  left       <= left - 1'b1;
                  rx_byte    <= {bit_val, acc};
                  byte_valid <= 1'b1;
                end
              end
            end
          end
        end
      end
    end
  end

  a_r9_one_pulse: assert property (@(posedge clk) disable iff (rst)
    $onehot0({byte_valid, eop, overflow}));

  a_r6_eop_idles: assert property (@(posedge clk) disable iff (rst)
    eop |-> !busy);

  a_r7_overflow_idles: assert property (@(posedge clk) disable iff (rst)
    overflow |-> !busy);

  a_r4_run_bounded: assert property (@(posedge clk) disable iff (rst)
    run <= RUN_W'(RUN_MAX));

  a_r2_on_grid: assert property (@(posedge clk) disable iff (rst)
    (byte_valid || eop || overflow) |-> $past(busy && phase == PH_W'(SAMPLE_AT)));

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !$past(busy) |-> !(byte_valid || eop || overflow));

  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!busy && prev && run == '0 && nbit == '0));
endmodule

// File: tb/lsusb_nrzi_rx_tb.sv
module lsusb_nrzi_rx_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic dp = 1'b0;
  logic dm = 1'b1;
  logic [7:0] limit = '0;
  logic [7:0] rx_byte;
  logic byte_valid, eop, overflow, busy;

  always #2.5 clk = ~clk;

  lsusb_nrzi_rx u_dut (.clk(clk), .rst(rst), .start(start), .dp(dp), .dm(dm),
    .limit(limit), .rx_byte(rx_byte), .byte_valid(byte_valid), .eop(eop),
    .overflow(overflow), .busy(busy));

  int total = 0;
  int bad = 0;
  bit done = 0;
  int cyc = 0;

  logic [7:0] tx [0:255];
  logic [7:0] rx [0:255];
  logic lv_dm [0:4095];
  logic lv_dp [0:4095];
  int nlv, se0_at, nrx, eop_cnt, ovf_cnt, eop_cyc;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (byte_valid) begin
      if (nrx < 256) rx[nrx] = rx_byte;
      nrx = nrx + 1;
    end
    if (eop) begin
      eop_cnt = eop_cnt + 1;
      eop_cyc = cyc;
    end
    if (overflow) ovf_cnt = ovf_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic encode(input int nb, input int extra);
    logic lvl;
    int ones;
    int nbits;
    logic b;
    lvl = 1'b0;
    ones = 1;
    nlv = 0;
    nbits = nb * 8 + extra;
    for (int i = 0; i < nbits; i++) begin
      if (i < nb * 8) b = tx[i / 8][i % 8];
      else b = (((8'h2D) >> (i % 8)) & 1) != 0;
      if (b) ones = ones + 1;
      else begin lvl = ~lvl; ones = 0; end
      lv_dm[nlv] = lvl; lv_dp[nlv] = ~lvl; nlv = nlv + 1;
      if (ones == 6) begin
        lvl = ~lvl; ones = 0;
        lv_dm[nlv] = lvl; lv_dp[nlv] = ~lvl; nlv = nlv + 1;
      end
    end
    se0_at = nlv;
    for (int j = 0; j < 2; j++) begin
      lv_dm[nlv] = 1'b0; lv_dp[nlv] = 1'b0; nlv = nlv + 1;
    end
  endtask

  task automatic run_pkt(input int lim, input int nb, input int extra, input string tag);
    int c0, expn;
    bit expo;
    encode(nb, extra);
    nrx = 0; eop_cnt = 0; ovf_cnt = 0; eop_cyc = -1;
    @(negedge clk);
    dm = 1'b0; dp = 1'b1; limit = 8'(lim); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    c0 = cyc;
    for (int i = 0; i < nlv; i++) begin
      dm = lv_dm[i]; dp = lv_dp[i];
      repeat (8) @(negedge clk);
    end
    dm = 1'b1; dp = 1'b0;
    repeat (16) @(negedge clk);
    expo = nb > lim;
    expn = expo ? lim : nb;
    chk(nrx == expn, {tag, " R5 R7 byte count"}, nrx, expn);
    for (int i = 0; i < expn && i < nrx; i++)
      chk(rx[i] == tx[i], {tag, " R3 R4 R5 byte value"}, rx[i], tx[i]);
    chk(ovf_cnt == (expo ? 1 : 0), {tag, " R7 overflow pulses"}, ovf_cnt, expo ? 1 : 0);
    chk(eop_cnt == (expo ? 0 : 1), {tag, " R6 eop pulses"}, eop_cnt, expo ? 0 : 1);
    if (!expo)
      chk(eop_cyc == c0 + 4 + 8 * se0_at, {tag, " R2 eop sample cycle"}, eop_cyc, c0 + 4 + 8 * se0_at);
    chk(!busy, {tag, " R6 R7 idle after packet"}, busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(!busy && !byte_valid && !eop && !overflow, "R1 reset state",
        {busy, byte_valid, eop, overflow}, 0);

    nrx = 0; eop_cnt = 0; ovf_cnt = 0;
    for (int i = 0; i < 48; i++) begin
      dm = i[1]; dp = i[2];
      @(negedge clk);
    end
    dm = 1'b1; dp = 1'b0;
    repeat (4) @(negedge clk);
    chk(nrx + eop_cnt + ovf_cnt == 0 && !busy, "R8 idle line ignored", nrx + eop_cnt + ovf_cnt, 0);

    tx[0] = 8'h00;
    run_pkt(4, 1, 0, "zero byte");

    for (int p = 0; p < 16; p++) begin
      for (int i = 0; i < 16; i++) tx[i] = 8'(p * 16 + i);
      run_pkt(16, 16, 0, "sweep");
    end

    for (int i = 0; i < 5; i++) tx[i] = 8'hFF;
    run_pkt(8, 5, 0, "ones run");

    tx[0] = 8'h7E; tx[1] = 8'hFC; tx[2] = 8'h3F; tx[3] = 8'h80;
    run_pkt(8, 4, 0, "stuff across bytes");

    tx[0] = 8'hA5; tx[1] = 8'h3C;
    run_pkt(8, 2, 5, "partial byte");

    for (int i = 0; i < 4; i++) tx[i] = 8'(8'h11 * (i + 1));
    run_pkt(2, 4, 0, "overflow");

    tx[0] = 8'h55;
    run_pkt(0, 1, 0, "zero budget");

    tx[0] = 8'hC3; tx[1] = 8'hFF;
    run_pkt(2, 2, 0, "exact budget");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total = total + 1;
      bad = bad + 1;
      $display("FAIL watchdog R2 actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule